// File: doc/BRIEF.md
# Word Load/Store Memory Unit

This unit serves the data-memory side of a 32-bit load/store machine. Each request carries a 32-bit base value, a signed 16-bit displacement, a write-enable bit and, for stores, a 32-bit data word. The unit adds the sign-extended displacement to the base to form a byte address. It checks that the address falls on a 4-byte boundary. It then moves one whole word into or out of a byte-addressed store held inside the block.

The bytes of a word sit in four consecutive byte locations. A parameter selects how the bytes of the word map onto those locations: most significant byte first, or least significant byte first. A request whose address is not a multiple of four does not touch memory. It returns a fault instead. Every accepted request gets exactly one response on the following clock edge.

Top module: `lsu_word_mem`

## Requirements
- R1: The effective byte address is `base_i` plus `offset_i` sign-extended to 32 bits, modulo 2^32. Any carry out of bit 31 is dropped, and a negative displacement reaches lower addresses.
- R2: An aligned load returns the word most recently stored at the same effective address. For example, a store of 42 at base 3000, offset 8, is read back as 42 by a load at base 3000, offset 8.
- R3: When the two low bits of the effective address are not both zero, the response has `rsp_fault_o`=1 and `rdata_o`=0. The fault lasts only that one response cycle.
- R4: A misaligned store leaves memory unchanged.
- R5: Parameter `BIG_ENDIAN`=1 places data bits 31:24 at the lowest byte address of the word. `BIG_ENDIAN`=0 places bits 7:0 there. A store followed by a load returns the original word under either order.
- R6: Effective-address bits at and above log2(`MEM_BYTES`) are ignored, so addresses wrap modulo the memory size.
- R7: A request with `req_valid_i`=1 produces `rsp_valid_o`=1 on the next clock edge. A cycle without a request produces `rsp_valid_o`=0 on the next edge.
- R8: Reset (`rst_ni`=0) forces `rsp_valid_o`, `rsp_fault_o` and `rdata_o` to 0. Memory contents survive reset.
- R9: An aligned store responds with `rsp_fault_o`=0 and `rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_we_i | input | 1 | 1 = store, 0 = load |
| base_i | input | 32 | Base address value |
| offset_i | input | 16 | Signed byte displacement |
| wdata_i | input | 32 | Store data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_fault_o | output | 1 | Misalignment fault |
| rdata_o | output | 32 | Load data, zero for stores and faults |

## Verification
The bench builds two copies of the unit and drives both with the same stimulus. The default copy uses 1024 bytes with least-significant-byte-first order. The second uses 256 bytes with most-significant-byte-first order. With the two sizes, a single set of wrapped addresses (1040 and 2064 land on byte 16 in both) tests the discarding of upper address bits at two different widths. With the two byte orders, every store and load checks the lane arrangement in both directions. The addresses near 3000 map to different physical words in the two sizes, and a base of 0xFFFFFFFC is used to check that the carry out of bit 31 is dropped.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned XLEN       = WORD_BYTES * BYTE_W;
  localparam int unsigned OFF_W      = 16;

  typedef logic [WORD_BYTES-1:0][BYTE_W-1:0] lanes_t;  // index = byte offset within word
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
(
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [XLEN-1:0]  ea_o,
  output logic             misaligned_o
);
  logic [XLEN-1:0] off_sext;

  assign off_sext     = {{(XLEN-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign ea_o         = base_i + off_sext;  // carry out of bit 31 dropped
  assign misaligned_o = |ea_o[1:0];
endmodule

// File: rtl/lsu_lane_order.sv
module lsu_lane_order
  import lsu_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [XLEN-1:0] word_i,
  output lanes_t          lanes_o,
  input  lanes_t          lanes_i,
  output logic [XLEN-1:0] word_o
);
  for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
    localparam int unsigned SIG = BIG_ENDIAN ? (WORD_BYTES - 1 - l) : l;
    assign lanes_o[l]              = word_i[SIG*BYTE_W +: BYTE_W];
    assign word_o[SIG*BYTE_W +: BYTE_W] = lanes_i[l];
  end
endmodule

// File: rtl/lsu_lane_mem.sv
module lsu_lane_mem
  import lsu_pkg::*;
#(
  parameter int unsigned WORDS = 256,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  lanes_t           wr_lanes_i,
  output lanes_t           rd_lanes_o
);
  for (genvar l = 0; l < WORD_BYTES; l++) begin : g_bank
    logic [BYTE_W-1:0] bank_q [WORDS];

    always_ff @(posedge clk_i) begin
      if (we_i) bank_q[idx_i] <= wr_lanes_i[l];
    end

    assign rd_lanes_o[l] = bank_q[idx_i];
  end
endmodule

// File: rtl/lsu_word_mem.sv
module lsu_word_mem
  import lsu_pkg::*;
#(
  parameter int unsigned MEM_BYTES  = 1024,
  parameter bit          BIG_ENDIAN = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_we_i,
  input  logic [31:0] base_i,
  input  logic [15:0] offset_i,
  input  logic [31:0] wdata_i,
  output logic        rsp_valid_o,
  output logic        rsp_fault_o,
  output logic [31:0] rdata_o
);
  localparam int unsigned WORDS = MEM_BYTES / WORD_BYTES;
  localparam int unsigned IDX_W = $clog2(WORDS);

  logic [XLEN-1:0]  ea;
  logic             misaligned;
  logic [IDX_W-1:0] word_idx;
  logic             mem_we;
  lanes_t           wr_lanes;
  lanes_t           rd_lanes;
  logic [XLEN-1:0]  rd_word;

  lsu_agen u_agen (
    .base_i      (base_i),
    .offset_i    (offset_i),
    .ea_o        (ea),
    .misaligned_o(misaligned)
  );

  lsu_lane_order #(.BIG_ENDIAN(BIG_ENDIAN)) u_order (
    .word_i (wdata_i),
    .lanes_o(wr_lanes),
    .lanes_i(rd_lanes),
    .word_o (rd_word)
  );

  // upper address bits wrap away
  assign word_idx = ea[IDX_W+1:2];
  assign mem_we   = req_valid_i & req_we_i & ~misaligned;

  lsu_lane_mem #(.WORDS(WORDS)) u_mem (
    .clk_i     (clk_i),
    .we_i      (mem_we),
    .idx_i     (word_idx),
    .wr_lanes_i(wr_lanes),
    .rd_lanes_o(rd_lanes)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_fault_o <= req_valid_i & misaligned;
      rdata_o     <= (req_valid_i && !req_we_i && !misaligned) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/lsu_word_mem_chk.sv
module lsu_word_mem_chk
  import lsu_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_we_i,
  input logic [31:0]     base_i,
  input logic [15:0]     offset_i,
  input logic [31:0]     wdata_i,
  input logic            rsp_valid_o,
  input logic            rsp_fault_o,
  input logic [31:0]     rdata_o,
  input logic [XLEN-1:0] ea,
  input logic            mem_we,
  input lanes_t          wr_lanes
);
  logic lo_bad;
  assign lo_bad = |(base_i[1:0] + offset_i[1:0]);

  a_r1_ea_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ea == base_i + {{16{offset_i[15]}}, offset_i});

  a_r3_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && lo_bad) |=> (rsp_fault_o && rdata_o == '0));

  a_r3_fault_only_on_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && lo_bad) |=> !rsp_fault_o);

  a_r4_no_bad_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && lo_bad) |-> !mem_we);

  a_r5_low_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> wr_lanes[0] == (BIG_ENDIAN ? wdata_i[31:24] : wdata_i[7:0]));

  a_r7_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r9_store_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i) |=> rdata_o == '0);
endmodule

bind lsu_word_mem lsu_word_mem_chk #(.BIG_ENDIAN(BIG_ENDIAN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_we_i   (req_we_i),
  .base_i     (base_i),
  .offset_i   (offset_i),
  .wdata_i    (wdata_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_fault_o(rsp_fault_o),
  .rdata_o    (rdata_o),
  .ea         (ea),
  .mem_we     (mem_we),
  .wr_lanes   (wr_lanes)
);

// File: tb/lsu_word_mem_tb.sv
module lsu_word_mem_tb;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic        we;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] wd;
    logic        fault;
    logic [31:0] rd;
    logic [7:0]  req;  // requirement number for messages
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'd3000,       16'd8,      32'd42,         1'b0, 32'd0,          8'd9},
    '{1'b0, 32'd3000,       16'd8,      32'd0,          1'b0, 32'd42,         8'd2},
    '{1'b1, 32'd0,          16'd0,      32'hA5A5_1234,  1'b0, 32'd0,          8'd9},
    '{1'b0, 32'd4,          16'hFFFC,   32'd0,          1'b0, 32'hA5A5_1234,  8'd1},
    '{1'b0, 32'd1,          16'd0,      32'd0,          1'b1, 32'd0,          8'd3},
    '{1'b1, 32'd3008,       16'd2,      32'hFFFF_FFFF,  1'b1, 32'd0,          8'd3},
    '{1'b0, 32'd3000,       16'd8,      32'd0,          1'b0, 32'd42,         8'd4},
    '{1'b1, 32'hFFFF_FFFC,  16'd8,      32'h1122_3344,  1'b0, 32'd0,          8'd1},
    '{1'b0, 32'd4,          16'd0,      32'd0,          1'b0, 32'h1122_3344,  8'd1},
    '{1'b0, 32'd0,          16'd0,      32'd0,          1'b0, 32'hA5A5_1234,  8'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] off = '0;
  logic [31:0] wdata = '0;
  logic        v_le, f_le, v_be, f_be;
  logic [31:0] d_le, d_be;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_word_mem u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .base_i(base), .offset_i(off), .wdata_i(wdata),
    .rsp_valid_o(v_le), .rsp_fault_o(f_le), .rdata_o(d_le)
  );

  lsu_word_mem #(.MEM_BYTES(256), .BIG_ENDIAN(1'b1)) u_dut_be (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .base_i(base), .offset_i(off), .wdata_i(wdata),
    .rsp_valid_o(v_be), .rsp_fault_o(f_be), .rdata_o(d_be)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on negedge, result registered at posedge, sampled next negedge
  task automatic issue(input logic we, input logic [31:0] b, input logic [15:0] o,
                       input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; base = b; off = o; wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic chk_both(input string req, input logic fault, input logic [31:0] rd);
    chk({req, " valid le"}, {31'd0, v_le}, 32'd1);
    chk({req, " fault le"}, {31'd0, f_le}, {31'd0, fault});
    chk({req, " data le"},  d_le, rd);
    chk({req, " valid be"}, {31'd0, v_be}, 32'd1);
    chk({req, " fault be"}, {31'd0, f_be}, {31'd0, fault});
    chk({req, " data be"},  d_be, rd);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 rst valid", {31'd0, v_le}, 32'd0);
    chk("R8 rst fault", {31'd0, f_le}, 32'd0);
    chk("R8 rst data",  d_le, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R1 R2 R3 R4 R5 R9
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].we, VECS[i].base, VECS[i].off, VECS[i].wd);
      chk_both($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].fault, VECS[i].rd);
    end

    // R3: fault lasts one cycle
    issue(1'b0, 32'd2, 16'd0, 32'd0);
    chk("R3 fault set", {31'd0, f_le}, 32'd1);
    @(negedge clk);
    chk("R3 fault cleared", {31'd0, f_le}, 32'd0);
    // R7: idle cycle gives no response
    chk("R7 idle le", {31'd0, v_le}, 32'd0);
    chk("R7 idle be", {31'd0, v_be}, 32'd0);

    // R6: wrap, 1040 and 2064 land on byte 16 in both sizes
    issue(1'b1, 32'd1040, 16'd0, 32'hCAFE_0016);
    issue(1'b0, 32'd16, 16'd0, 32'd0);
    chk_both("R6 wrap 1040->16", 1'b0, 32'hCAFE_0016);
    issue(1'b0, 32'd2064, 16'd0, 32'd0);
    chk_both("R6 wrap 2064->16", 1'b0, 32'hCAFE_0016);

    // R5: distinct byte values round-trip under both orders
    issue(1'b1, 32'd20, 16'd0, 32'h0102_0304);
    issue(1'b0, 32'd24, 16'hFFFC, 32'd0);
    chk_both("R5 round trip", 1'b0, 32'h0102_0304);

    // R8: reset mid-run, memory retained
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 rst2 valid", {31'd0, v_le}, 32'd0);
    rst_n = 1'b1;
    issue(1'b0, 32'd16, 16'd0, 32'd0);
    chk_both("R8 mem kept", 1'b0, 32'hCAFE_0016);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule